// File: doc/BRIEF.md
# Critical-Word-First Line Fill Buffer

This block stages cache lines coming back from memory after a miss. It has eight entries. Each one is claimed when a miss-buffer entry issues its read to memory, and it records the line address, the index of the critical 16-byte quad-word, and whether the read allocates into the cache. Memory then returns the line as four 128-bit beats. The critical quad-word comes first and the rest follow in wrapped order. Each beat carries an entry tag, so beats for different lines may interleave.

The first beat of an allocating line wakes the waiting load and forwards that beat as bypass data. When the fourth beat has arrived, the entry presents a fill request to the cache pipeline with its address and the whole assembled line. The pipeline's acknowledge frees the entry. A non-allocating line takes a different path: each beat is passed straight to an I/O port as it arrives, and the entry frees itself after the last beat. An entry can only be claimed while the issuing miss-buffer entry's valid bit is set, so the two valid bits are set in that order but may clear in either order. When every entry is busy, the block raises full, which holds back new memory requests.

Top module: `line_fill_buf`

## Requirements
- R1: After reset no entry is valid, `full` is low, and `wake_valid`, `io_valid` and `fill_req_valid` are low.
- R2: A request is accepted on a clock edge where `alloc_valid`, `alloc_mb_vld` are high and `full` is low. It takes the lowest-numbered free entry, which `alloc_id` reports in the same cycle, and that bit of `ent_valid` is high from the next cycle.
- R3: A request made while `alloc_mb_vld` is low claims no entry, and `ent_valid` is unchanged by it.
- R4: `full` is high exactly when all eight entries are valid. A request made while `full` is high claims no entry.
- R5: The n-th beat (n = 0..3) returned for an entry is stored as quad-word (critical index + n) mod 4. Quad-word q occupies bits [q*128 +: 128] of the line.
- R6: The first beat of an allocating entry produces a one-cycle `wake_valid` pulse in the next cycle, carrying that entry's tag and the beat data. Later beats produce no wakeup.
- R7: From the cycle after an allocating entry receives its fourth beat, `fill_req_valid` is high. It shows the tag, address and full line of the lowest-numbered complete entry and stays high until that entry is acknowledged.
- R8: `fill_ack` while `fill_req_valid` is high clears the presented entry's valid bit in the next cycle.
- R9: Each beat of a non-allocating entry appears on the I/O port in the next cycle, with its tag, its quad-word index (R5) and `io_last` high on the fourth beat. Such an entry never wakes and never requests a fill, and it is invalid from the cycle after its fourth beat.
- R10: Returns are routed by `ret_tag`, so beats for several entries may interleave in any order without disturbing one another.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| alloc_valid | input | 1 | Miss-buffer issue request |
| alloc_mb_vld | input | 1 | Valid bit of the issuing miss-buffer entry |
| alloc_addr | input | 40 | Line address of the request |
| alloc_crit | input | 2 | Critical quad-word index |
| alloc_nal | input | 1 | Request is non-allocating (drain to I/O) |
| alloc_id | output | 3 | Entry a request this cycle would take |
| full | output | 1 | All entries valid |
| ret_valid | input | 1 | Memory return beat present |
| ret_tag | input | 3 | Entry the beat belongs to |
| ret_data | input | 128 | Beat data |
| wake_valid | output | 1 | Critical-beat wakeup pulse |
| wake_tag | output | 3 | Entry of the wakeup |
| wake_data | output | 128 | Bypassed critical quad-word |
| io_valid | output | 1 | Drained beat present |
| io_tag | output | 3 | Entry of the drained beat |
| io_qw | output | 2 | Quad-word index of the drained beat |
| io_data | output | 128 | Drained beat data |
| io_last | output | 1 | Final beat of the drained line |
| fill_req_valid | output | 1 | A complete line awaits filling |
| fill_req_tag | output | 3 | Entry being presented |
| fill_req_addr | output | 40 | Address of the presented line |
| fill_req_line | output | 512 | Assembled line |
| fill_ack | input | 1 | Pipeline accepts the presented fill |
| ent_valid | output | 8 | Per-entry valid bits |

## Verification
The embedded properties assume that memory returns only carry the tag of a live entry that still has fewer than four beats. They also assume that the pipeline acknowledges a fill only while a fill request is shown. The stimulus respects both rules by choosing return tags and acknowledges from the bench's own model of the entries. Apart from those two rules, requests, the miss-buffer valid bit, line kinds and critical indices vary freely, and a request-heavy phase drives the buffer to full.

// File: rtl/fb_pkg.sv
package fb_pkg;
    localparam int LINE_BEATS = 4;
    localparam int QW_W       = 2;
    localparam int CNT_W      = 3;
    typedef logic [QW_W-1:0] qw_idx_t;
endpackage

// File: rtl/fb_first_set.sv
module fb_first_set #(
    parameter int N = 8
) (
    input  logic [N-1:0]         req,
    output logic                 found,
    output logic [$clog2(N)-1:0] idx,
    output logic [N-1:0]         onehot
);
    localparam int IW = $clog2(N);

    always_comb begin
        found  = 1'b0;
        idx    = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) begin
                found = 1'b1;
                idx   = IW'(i);
            end
        end
        onehot = found ? (N'(1) << idx) : '0;
    end
endmodule

// File: rtl/fb_entry.sv
module fb_entry
    import fb_pkg::*;
#(
    parameter int ADDR_W = 40,
    parameter int BEAT_W = 128
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               alloc_en,
    input  logic [ADDR_W-1:0]                  alloc_addr,
    input  qw_idx_t                            alloc_crit,
    input  logic                               alloc_nal,
    input  logic                               beat_en,
    input  logic [BEAT_W-1:0]                  beat_data,
    input  logic                               ack_en,
    output logic                               vld,
    output logic                               nal,
    output logic [ADDR_W-1:0]                  addr,
    output logic [BEAT_W*LINE_BEATS-1:0]       line,
    output qw_idx_t                            beat_slot,
    output logic                               beat_first,
    output logic                               beat_last,
    output logic                               fill_rdy
);
    localparam int LINE_W = BEAT_W * LINE_BEATS;

    typedef struct packed {
        logic              vld;
        logic              nal;
        logic [ADDR_W-1:0] addr;
        qw_idx_t           crit;
        logic [CNT_W-1:0]  cnt;
        logic [LINE_W-1:0] line;
    } ent_t;

    ent_t ent_q, ent_d;

    always_comb begin
        ent_d = ent_q;
        if (alloc_en) begin
            ent_d.vld  = 1'b1;
            ent_d.nal  = alloc_nal;
            ent_d.addr = alloc_addr;
            ent_d.crit = alloc_crit;
            ent_d.cnt  = '0;
            ent_d.line = '0;
        end
        if (beat_en) begin
            for (int b = 0; b < LINE_BEATS; b++) begin
                if (beat_slot == QW_W'(b)) begin
                    ent_d.line[b*BEAT_W +: BEAT_W] = beat_data;
                end
            end
            ent_d.cnt = ent_q.cnt + CNT_W'(1);
            if (ent_q.nal && beat_last) begin
                ent_d.vld = 1'b0;
            end
        end
        if (ack_en) begin
            ent_d.vld = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ent_q <= '0;
        end else begin
            ent_q <= ent_d;
        end
    end

    assign vld        = ent_q.vld;
    assign nal        = ent_q.nal;
    assign addr       = ent_q.addr;
    assign line       = ent_q.line;
    assign beat_slot  = ent_q.crit + ent_q.cnt[QW_W-1:0];
    assign beat_first = (ent_q.cnt == '0);
    assign beat_last  = (ent_q.cnt == CNT_W'(LINE_BEATS - 1));
    assign fill_rdy   = ent_q.vld && !ent_q.nal && (ent_q.cnt == CNT_W'(LINE_BEATS));

    AST_BEAT_ON_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
        beat_en |-> (ent_q.vld && ent_q.cnt < CNT_W'(LINE_BEATS))); // R10
    AST_ALLOC_FREE: assert property (@(posedge clk) disable iff (!rst_n)
        alloc_en |-> !ent_q.vld); // R2
    AST_ACK_COMPLETE: assert property (@(posedge clk) disable iff (!rst_n)
        ack_en |-> fill_rdy); // R8
    AST_DRAIN_RETIRE: assert property (@(posedge clk) disable iff (!rst_n)
        (beat_en && ent_q.nal && beat_last && !alloc_en) |=> !vld); // R9
endmodule

// File: rtl/line_fill_buf.sv
module line_fill_buf
    import fb_pkg::*;
#(
    parameter int NUM_ENT = 8,
    parameter int ADDR_W  = 40,
    parameter int BEAT_W  = 128
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          alloc_valid,
    input  logic                          alloc_mb_vld,
    input  logic [ADDR_W-1:0]             alloc_addr,
    input  logic [1:0]                    alloc_crit,
    input  logic                          alloc_nal,
    output logic [$clog2(NUM_ENT)-1:0]    alloc_id,
    output logic                          full,
    input  logic                          ret_valid,
    input  logic [$clog2(NUM_ENT)-1:0]    ret_tag,
    input  logic [BEAT_W-1:0]             ret_data,
    output logic                          wake_valid,
    output logic [$clog2(NUM_ENT)-1:0]    wake_tag,
    output logic [BEAT_W-1:0]             wake_data,
    output logic                          io_valid,
    output logic [$clog2(NUM_ENT)-1:0]    io_tag,
    output logic [1:0]                    io_qw,
    output logic [BEAT_W-1:0]             io_data,
    output logic                          io_last,
    output logic                          fill_req_valid,
    output logic [$clog2(NUM_ENT)-1:0]    fill_req_tag,
    output logic [ADDR_W-1:0]             fill_req_addr,
    output logic [BEAT_W*LINE_BEATS-1:0]  fill_req_line,
    input  logic                          fill_ack,
    output logic [NUM_ENT-1:0]            ent_valid
);
    localparam int IW     = $clog2(NUM_ENT);
    localparam int LINE_W = BEAT_W * LINE_BEATS;

    typedef struct packed {
        logic              wake_v;
        logic              io_v;
        logic [IW-1:0]     tag;
        qw_idx_t           qw;
        logic              last;
        logic [BEAT_W-1:0] data;
    } out_t;

    out_t out_q, out_d;

    logic [NUM_ENT-1:0] vld_w, nal_w, first_w, last_w, rdy_w;
    logic [NUM_ENT-1:0] alloc_en_w, beat_en_w, ack_en_w;
    logic [NUM_ENT-1:0] free_oh, fill_oh;
    logic               free_found, fill_found, alloc_fire;
    logic [IW-1:0]      free_idx, fill_idx;
    logic [ADDR_W-1:0]  addr_a [NUM_ENT];
    logic [LINE_W-1:0]  line_a [NUM_ENT];
    qw_idx_t            slot_a [NUM_ENT];

    fb_first_set #(.N(NUM_ENT)) u_free_pick (
        .req    (~vld_w),
        .found  (free_found),
        .idx    (free_idx),
        .onehot (free_oh)
    );

    fb_first_set #(.N(NUM_ENT)) u_fill_pick (
        .req    (rdy_w),
        .found  (fill_found),
        .idx    (fill_idx),
        .onehot (fill_oh)
    );

    assign full       = !free_found;
    assign alloc_id   = free_idx;
    assign alloc_fire = alloc_valid && alloc_mb_vld && free_found;

    for (genvar g = 0; g < NUM_ENT; g++) begin : g_ent
        assign alloc_en_w[g] = alloc_fire && free_oh[g];
        assign beat_en_w[g]  = ret_valid && (ret_tag == IW'(g));
        assign ack_en_w[g]   = fill_ack && fill_found && fill_oh[g];

        fb_entry #(.ADDR_W(ADDR_W), .BEAT_W(BEAT_W)) u_ent (
            .clk        (clk),
            .rst_n      (rst_n),
            .alloc_en   (alloc_en_w[g]),
            .alloc_addr (alloc_addr),
            .alloc_crit (alloc_crit),
            .alloc_nal  (alloc_nal),
            .beat_en    (beat_en_w[g]),
            .beat_data  (ret_data),
            .ack_en     (ack_en_w[g]),
            .vld        (vld_w[g]),
            .nal        (nal_w[g]),
            .addr       (addr_a[g]),
            .line       (line_a[g]),
            .beat_slot  (slot_a[g]),
            .beat_first (first_w[g]),
            .beat_last  (last_w[g]),
            .fill_rdy   (rdy_w[g])
        );
    end

    always_comb begin
        logic    sel_nal, sel_first, sel_last;
        qw_idx_t sel_slot;
        sel_nal   = 1'b0;
        sel_first = 1'b0;
        sel_last  = 1'b0;
        sel_slot  = '0;
        for (int i = 0; i < NUM_ENT; i++) begin
            if (ret_tag == IW'(i)) begin
                sel_nal   = nal_w[i];
                sel_first = first_w[i];
                sel_last  = last_w[i];
                sel_slot  = slot_a[i];
            end
        end
        out_d        = out_q;
        out_d.wake_v = ret_valid && !sel_nal && sel_first;
        out_d.io_v   = ret_valid && sel_nal;
        if (ret_valid) begin
            out_d.tag  = ret_tag;
            out_d.qw   = sel_slot;
            out_d.last = sel_last;
            out_d.data = ret_data;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_q <= '0;
        end else begin
            out_q <= out_d;
        end
    end

    assign wake_valid     = out_q.wake_v;
    assign wake_tag       = out_q.tag;
    assign wake_data      = out_q.data;
    assign io_valid       = out_q.io_v;
    assign io_tag         = out_q.tag;
    assign io_qw          = out_q.qw;
    assign io_data        = out_q.data;
    assign io_last        = out_q.io_v && out_q.last;
    assign fill_req_valid = fill_found;
    assign fill_req_tag   = fill_idx;
    assign fill_req_addr  = addr_a[fill_idx];
    assign fill_req_line  = line_a[fill_idx];
    assign ent_valid      = vld_w;

    AST_ALLOC_NEEDS_MB: assert property (@(posedge clk) disable iff (!rst_n)
        (|(vld_w & ~$past(vld_w))) |-> $past(alloc_valid && alloc_mb_vld)); // R3
    AST_NO_ALLOC_WHEN_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        full |=> ((vld_w & ~$past(vld_w)) == '0)); // R4
    AST_WAKE_IO_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(wake_valid && io_valid)); // R6
    AST_FILL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_req_valid && !fill_ack) |=> fill_req_valid); // R7
    AST_ACK_ONLY_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
        fill_ack |-> fill_req_valid); // R8
    AST_WAKE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        wake_valid |-> !$past(wake_valid && ret_valid && ret_tag == wake_tag)); // R6
endmodule

// File: tb/line_fill_buf_bench.sv
module line_fill_buf_bench;
    localparam int N  = 8;
    localparam int AW = 40;
    localparam int BW = 128;
    localparam int LW = 512;
    localparam int IW = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic alloc_valid = 0, alloc_mb_vld = 0, alloc_nal = 0;
    logic [AW-1:0] alloc_addr = '0;
    logic [1:0] alloc_crit = '0;
    logic [IW-1:0] alloc_id;
    logic full;
    logic ret_valid = 0;
    logic [IW-1:0] ret_tag = '0;
    logic [BW-1:0] ret_data = '0;
    logic wake_valid, io_valid, io_last, fill_req_valid;
    logic [IW-1:0] wake_tag, io_tag, fill_req_tag;
    logic [BW-1:0] wake_data, io_data;
    logic [1:0] io_qw;
    logic [AW-1:0] fill_req_addr;
    logic [LW-1:0] fill_req_line;
    logic fill_ack = 0;
    logic [N-1:0] ent_valid;

    always #4 clk = ~clk;

    line_fill_buf u_line_fill_buf (
        .clk(clk), .rst_n(rst_n),
        .alloc_valid(alloc_valid), .alloc_mb_vld(alloc_mb_vld), .alloc_addr(alloc_addr),
        .alloc_crit(alloc_crit), .alloc_nal(alloc_nal), .alloc_id(alloc_id), .full(full),
        .ret_valid(ret_valid), .ret_tag(ret_tag), .ret_data(ret_data),
        .wake_valid(wake_valid), .wake_tag(wake_tag), .wake_data(wake_data),
        .io_valid(io_valid), .io_tag(io_tag), .io_qw(io_qw), .io_data(io_data), .io_last(io_last),
        .fill_req_valid(fill_req_valid), .fill_req_tag(fill_req_tag),
        .fill_req_addr(fill_req_addr), .fill_req_line(fill_req_line),
        .fill_ack(fill_ack), .ent_valid(ent_valid)
    );

    int checks = 0;
    int errors = 0;
    bit seen_full = 0;

    // behavioural model
    bit            m_vld [N];
    bit            m_nal [N];
    logic [AW-1:0] m_addr [N];
    int            m_crit [N];
    int            m_cnt [N];
    logic [LW-1:0] m_line [N];
    bit            e_wv, e_iv, e_il;
    int            e_tag, e_qw;
    logic [BW-1:0] e_data;

    task automatic chk(input bit ok, input string req, input logic [LW-1:0] act, input logic [LW-1:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic int lowest_free();
        for (int i = 0; i < N; i++) if (!m_vld[i]) return i;
        return -1;
    endfunction

    function automatic int lowest_ready();
        for (int i = 0; i < N; i++) if (m_vld[i] && !m_nal[i] && m_cnt[i] == 4) return i;
        return -1;
    endfunction

    task automatic compare();
        logic [N-1:0] vv;
        int fr, fp;
        for (int i = 0; i < N; i++) vv[i] = m_vld[i];
        fr = lowest_free();
        fp = lowest_ready();
        if (fr < 0) seen_full = 1;
        // R2 R3 R8 R9: valid bits follow allocation, ignored requests and retirement
        chk(ent_valid == vv, "R2 R3 R8 R9 ent_valid", LW'(ent_valid), LW'(vv));
        chk(full == (fr < 0), "R4 full", LW'(full), LW'(fr < 0));
        if (fr >= 0) chk(alloc_id == IW'(fr), "R2 alloc_id", LW'(alloc_id), LW'(fr));
        chk(wake_valid == e_wv, "R6 wake_valid", LW'(wake_valid), LW'(e_wv));
        if (e_wv) begin
            chk(wake_tag == IW'(e_tag), "R6 R10 wake_tag", LW'(wake_tag), LW'(e_tag));
            chk(wake_data == e_data, "R6 wake_data", LW'(wake_data), LW'(e_data));
        end
        chk(io_valid == e_iv, "R9 io_valid", LW'(io_valid), LW'(e_iv));
        if (e_iv) begin
            chk(io_tag == IW'(e_tag), "R9 R10 io_tag", LW'(io_tag), LW'(e_tag));
            chk(io_qw == 2'(e_qw), "R5 R9 io_qw", LW'(io_qw), LW'(e_qw));
            chk(io_data == e_data, "R9 io_data", LW'(io_data), LW'(e_data));
            chk(io_last == e_il, "R9 io_last", LW'(io_last), LW'(e_il));
        end
        chk(fill_req_valid == (fp >= 0), "R7 fill_req_valid", LW'(fill_req_valid), LW'(fp >= 0));
        if (fp >= 0) begin
            chk(fill_req_tag == IW'(fp), "R7 fill_req_tag", LW'(fill_req_tag), LW'(fp));
            chk(fill_req_addr == m_addr[fp], "R7 fill_req_addr", LW'(fill_req_addr), LW'(m_addr[fp]));
            chk(fill_req_line == m_line[fp], "R5 R7 fill_req_line", fill_req_line, m_line[fp]);
        end
    endtask

    task automatic drive_and_model(input int pa, input int pr, input int pk);
        int cand [$];
        int fr, fp, t, slot;
        fr = lowest_free();
        fp = lowest_ready();
        alloc_valid  = ($urandom_range(99) < pa);
        alloc_mb_vld = ($urandom_range(99) < 80);
        alloc_addr   = {8'($urandom), 32'($urandom)};
        alloc_crit   = 2'($urandom);
        alloc_nal    = ($urandom_range(99) < 30);
        for (int i = 0; i < N; i++) if (m_vld[i] && m_cnt[i] < 4) cand.push_back(i);
        ret_valid = (cand.size() > 0) && ($urandom_range(99) < pr);
        t = (cand.size() > 0) ? cand[$urandom_range(cand.size() - 1)] : 0;
        ret_tag  = IW'(t);
        ret_data = {$urandom, $urandom, $urandom, $urandom};
        fill_ack = (fp >= 0) && ($urandom_range(99) < pk);

        // model update for the coming edge
        e_wv = 0;
        e_iv = 0;
        if (fill_ack) m_vld[fp] = 0;                     // R8
        if (ret_valid) begin                              // R10: routed by tag
            slot = (m_crit[t] + m_cnt[t]) % 4;            // R5
            m_line[t][slot*BW +: BW] = ret_data;
            e_tag  = t;
            e_data = ret_data;
            e_qw   = slot;
            e_il   = (m_cnt[t] == 3);
            e_wv   = !m_nal[t] && m_cnt[t] == 0;          // R6
            e_iv   = m_nal[t];                            // R9
            m_cnt[t]++;
            if (m_nal[t] && m_cnt[t] == 4) m_vld[t] = 0;
        end
        if (alloc_valid && alloc_mb_vld && fr >= 0) begin // R2 R3 R4
            m_vld[fr]  = 1;
            m_nal[fr]  = alloc_nal;
            m_addr[fr] = alloc_addr;
            m_crit[fr] = alloc_crit;
            m_cnt[fr]  = 0;
            m_line[fr] = '0;
        end
    endtask

    task automatic phase(input int cycles, input int pa, input int pr, input int pk);
        for (int c = 0; c < cycles; c++) begin
            @(negedge clk);
            compare();
            drive_and_model(pa, pr, pk);
        end
    endtask

    initial begin
        for (int i = 0; i < N; i++) begin
            m_vld[i] = 0; m_nal[i] = 0; m_addr[i] = '0;
            m_crit[i] = 0; m_cnt[i] = 0; m_line[i] = '0;
        end
        e_wv = 0; e_iv = 0; e_il = 0; e_tag = 0; e_qw = 0; e_data = '0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk(ent_valid == '0 && !full && !wake_valid && !io_valid && !fill_req_valid,
            "R1 reset state", LW'({ent_valid, full, wake_valid, io_valid, fill_req_valid}), '0);
        phase(400, 90, 10, 20);    // request heavy: reaches full (R4)
        phase(3000, 45, 60, 50);   // mixed traffic with interleaved returns (R10)
        phase(400, 0, 90, 90);     // drain
        chk(seen_full, "R4 full reached", LW'(seen_full), LW'(1));
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(8 * 200000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule